// File: doc/BRIEF.md
# SDRAM Four-Beat Read Sequencer

This block sits on the controller side of a single-data-rate SDRAM and carries out one read burst of four beats for each accepted request. A request names a bank, a row and a starting column, and brings three small timing settings with it: the number of spacer cycles between the row open and the first column command, the CAS latency, and the number of cycles the bank needs to finish its automatic precharge once the burst is over. These settings are captured together with the request, so the next access may use different ones.

The sequencer drives registered command and address pins. An access opens the row, waits the requested spacer cycles, then issues four column reads back to back. The address steps through four consecutive columns, and the fourth read asks the device to precharge the row on its own. The four returning data words are captured once the CAS latency has run out, and each is presented for one cycle with a valid strobe. One fixed transfer cycle follows the last capture. After it, the bank just read stays closed to new requests for the precharge-wait count, while any other bank can be accepted at once.

Top module: `sdram_burst_rd`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pins carry no-operation (chip select low, RAS, CAS and WE high), `rd_valid` is low and the precharge-wait window is empty.
- R2: In the idle state `req_ack` is high in the same cycle as `req_valid` unless R7 blocks the request. In the next cycle the pins carry activate (chip select, RAS low; CAS, WE high), with `sd_ba` equal to the bank and `sd_addr` equal to the row.
- R3: After activate, `cfg_rcd` (0 to 3) further cycles carry no-operation before the first read. With 0, the first read directly follows activate.
- R4: Four read commands (chip select and CAS low; RAS and WE high) occupy four consecutive cycles. `sd_addr[8:0]` carries the start column plus 0, 1, 2, 3, wrapping within 9 bits. `sd_addr[10]` is high on the fourth read only, and all other address bits are low.
- R5: The CAS latency is `cfg_cl`+1 (1 to 4). With the first read in cycle t, `sd_dq` is sampled at the end of cycles t+CL through t+CL+3. Each sample appears on `rd_data`, with `rd_valid` high, in the following cycle, in beat order.
- R6: Exactly one transfer cycle follows the last data cycle. It carries no-operation, and it is the cycle in which the fourth beat is valid. The sequencer is idle, and can acknowledge, from cycle t+CL+5.
- R7: After a burst to bank B with `cfg_rp` = P, a request for B is not acknowledged during the first P idle cycles. A request for any other bank is acknowledged in the first idle cycle.
- R8: From acknowledge until idle, `req_ack` stays low whatever `req_valid` and the request inputs do. Changes to the request or configuration inputs after acknowledge do not alter the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ack | output | 1 | Request taken this cycle |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 13 | Row to open |
| req_col | input | 9 | First column of the burst |
| cfg_rcd | input | 2 | Spacer cycles between activate and first read |
| cfg_cl | input | 2 | CAS latency minus one |
| cfg_rp | input | 2 | Same-bank precharge-wait cycles |
| sd_cs_n | output | 1 | SDRAM chip select, low active |
| sd_ras_n | output | 1 | SDRAM row strobe, low active |
| sd_cas_n | output | 1 | SDRAM column strobe, low active |
| sd_we_n | output | 1 | SDRAM write enable, low active |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 13 | SDRAM address (row, or column with precharge flag on bit 10) |
| sd_dq | input | 16 | Read data from the SDRAM |
| rd_data | output | 16 | Captured read beat |
| rd_valid | output | 1 | `rd_data` holds a beat this cycle |

## Verification
Faults in the state or beat counter appear on the command pins within one cycle. A skipped or repeated read shows up as a wrong column, a misplaced bit 10 or a read where a no-operation belongs. A faulty latency count shifts the `rd_valid` strobes by whole cycles, so the words on `rd_data` no longer match the beats the bench placed on `sd_dq`; this is visible within the four data cycles. A wrong precharge-wait count or stored bank shows up only on the next access, as an acknowledge that comes early, late, or for the wrong bank. The bench therefore chains accesses with varied gaps and banks.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;
    localparam int unsigned BURST_LEN = 4;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_READ = 2'd2
    } sdrb_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_RCD  = 3'd2,
        ST_COL  = 3'd3,
        ST_LAT  = 3'd4,
        ST_TDE  = 3'd5
    } sdrb_state_e;
endpackage

// File: rtl/sdrb_dncnt.sv
module sdrb_dncnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/sdrb_cmd_enc.sv
module sdrb_cmd_enc
    import sdrb_pkg::*;
(
    input  sdrb_cmd_e cmd,
    output logic      cs_n,
    output logic      ras_n,
    output logic      cas_n,
    output logic      we_n
);
    always_comb begin
        cs_n = 1'b0;
        unique case (cmd)
            CMD_ACT:  {ras_n, cas_n, we_n} = 3'b011;
            CMD_READ: {ras_n, cas_n, we_n} = 3'b101;
            default:  {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end
endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
    import sdrb_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int AP_BIT = 10,
    parameter int CFG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [CFG_W-1:0]  cfg_rcd,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_rp,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    input  logic [DATA_W-1:0] sd_dq,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam int LAT_W  = CFG_W + 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);
    localparam logic [BEAT_W:0]   CAP_FULL  = (BEAT_W + 1)'(BURST_LEN);

    typedef struct packed {
        sdrb_state_e       state;
        logic [BEAT_W-1:0] beat;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [CFG_W-1:0]  cl;
        logic [CFG_W-1:0]  rp;
        logic [BEAT_W:0]   cap_left;
        logic [BANK_W-1:0] tap_bank;
        sdrb_cmd_e         cmd;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_IDLE, cmd: CMD_NOP, default: '0};

    seq_t seq_d, seq_q;

    logic accept, lat_load, capture, go_col;
    logic rcd_zero, lat_zero, tap_zero;
    logic [CFG_W-1:0] rcd_cnt, tap_cnt;
    logic [LAT_W-1:0] lat_cnt;
    logic             same_bank_block;

    function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] c,
                                                   input logic ap);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[COL_W-1:0] = c;
        a[AP_BIT]    = ap;
        return a;
    endfunction

    // Interval timers: spacer, latency, same-bank precharge wait
    sdrb_dncnt #(.W(CFG_W)) u_rcd_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_rcd),
        .en       ((seq_q.state == ST_ACT) || (seq_q.state == ST_RCD)),
        .count    (rcd_cnt),
        .is_zero  (rcd_zero)
    );

    sdrb_dncnt #(.W(LAT_W)) u_lat_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (LAT_W'(seq_q.cl) + LAT_W'(1)),
        .en       ((seq_q.cap_left != '0) && !lat_zero),
        .count    (lat_cnt),
        .is_zero  (lat_zero)
    );

    sdrb_dncnt #(.W(CFG_W)) u_tap_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_q.state == ST_TDE),
        .load_val (seq_q.rp),
        .en       (1'b1),
        .count    (tap_cnt),
        .is_zero  (tap_zero)
    );

    assign same_bank_block = !tap_zero && (req_bank == seq_q.tap_bank);
    assign req_ack = (seq_q.state == ST_IDLE) && req_valid && !same_bank_block;
    assign accept  = req_ack;

    always_comb begin
        logic [BEAT_W-1:0] nxt_beat;
        seq_d    = seq_q;
        seq_d.cmd    = CMD_NOP;
        seq_d.addr   = '0;
        seq_d.rvalid = 1'b0;
        lat_load = 1'b0;
        nxt_beat = seq_q.beat + BEAT_W'(1);
        go_col   = rcd_zero;
        capture  = (seq_q.cap_left != '0) && lat_zero;

        if (capture) begin
            seq_d.rdata    = sd_dq;
            seq_d.rvalid   = 1'b1;
            seq_d.cap_left = seq_q.cap_left - (BEAT_W + 1)'(1);
        end

        unique case (seq_q.state)
            ST_IDLE: begin
                if (accept) begin
                    seq_d.state = ST_ACT;
                    seq_d.bank  = req_bank;
                    seq_d.col   = req_col;
                    seq_d.cl    = cfg_cl;
                    seq_d.rp    = cfg_rp;
                    seq_d.cmd   = CMD_ACT;
                    seq_d.ba    = req_bank;
                    seq_d.addr  = ADDR_W'(req_row);
                end
            end
            ST_ACT, ST_RCD: begin
                if (go_col) begin
                    seq_d.state    = ST_COL;
                    seq_d.beat     = '0;
                    seq_d.cmd      = CMD_READ;
                    seq_d.addr     = col_addr(seq_q.col, 1'b0);
                    seq_d.cap_left = CAP_FULL;
                    lat_load       = 1'b1;
                end else begin
                    seq_d.state = ST_RCD;
                end
            end
            ST_COL: begin
                if (seq_q.beat == LAST_BEAT) begin
                    seq_d.state = ST_LAT;
                end else begin
                    seq_d.beat = nxt_beat;
                    seq_d.cmd  = CMD_READ;
                    seq_d.addr = col_addr(seq_q.col + COL_W'(nxt_beat),
                                          nxt_beat == LAST_BEAT);
                end
            end
            ST_LAT: begin
                if (capture && (seq_q.cap_left == (BEAT_W + 1)'(1))) begin
                    seq_d.state = ST_TDE;
                end
            end
            ST_TDE: begin
                seq_d.state    = ST_IDLE;
                seq_d.tap_bank = seq_q.bank;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    sdrb_cmd_enc u_cmd_enc (
        .cmd   (seq_q.cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    assign sd_ba    = seq_q.ba;
    assign sd_addr  = seq_q.addr;
    assign rd_data  = seq_q.rdata;
    assign rd_valid = seq_q.rvalid;

    logic unused_cnt;
    assign unused_cnt = ^{rcd_cnt, lat_cnt, tap_cnt};
endmodule

// File: rtl/sdram_burst_rd_chk.sv
module sdram_burst_rd_chk #(
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ack,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              rd_valid
);
    logic is_act, is_rd, is_nop;
    assign is_act = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign is_rd  = !sd_cs_n &&  sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;

    p_reset_nop_r1: assert property (@(posedge clk)
        !rst_n |=> (is_nop && !rd_valid));

    p_act_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> is_act);

    p_rd_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !sd_addr[AP_BIT]) |=> is_rd);

    p_rd_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && sd_addr[AP_BIT]) |=> is_nop);

    p_single_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    p_no_ack_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ack);
endmodule

bind sdram_burst_rd sdram_burst_rd_chk #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ack  (req_ack),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .rd_valid (rd_valid)
);

// File: tb/sdram_burst_rd_test.sv
module sdram_burst_rd_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ack;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [1:0]  cfg_rcd = '0, cfg_cl = '0, cfg_rp = '0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [15:0] sd_dq = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int errors = 0;
    int checks = 0;
    bit have_prev = 1'b0;
    logic [1:0] prev_bank = '0;
    int prev_rp = 0;

    always #4 clk = ~clk;

    sdram_burst_rd uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_rcd(cfg_rcd), .cfg_cl(cfg_cl), .cfg_rp(cfg_rp),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [3:0] cmd_of(input logic [1:0] kind);
        // 0 nop, 1 activate, 2 read : {cs_n, ras_n, cas_n, we_n}
        case (kind)
            2'd1:    return 4'b0011;
            2'd2:    return 4'b0101;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic logic [12:0] rd_addr(input logic [8:0] col, input int n);
        logic [8:0]  c;
        logic [12:0] a;
        c = col + 9'(n);
        a = 13'(c);
        if (n == 3) a[10] = 1'b1;
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_read(input logic [1:0] bank, input logic [12:0] row,
                           input logic [8:0] col, input logic [1:0] rcd,
                           input logic [1:0] cl, input logic [1:0] rp, input int gap);
        int lat;
        int wait_exp;
        int waited;
        logic [15:0] beats [4];
        logic [3:0]  pins;
        lat = int'(cl) + 1;
        for (int i = 0; i < 4; i++) beats[i] = 16'($urandom);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_exp = (have_prev && bank == prev_bank && prev_rp > gap) ? prev_rp - gap : 0;
        @(negedge clk);
        req_bank = bank; req_row = row; req_col = col;
        cfg_rcd = rcd; cfg_cl = cl; cfg_rp = rp;
        req_valid = 1'b1;
        #1;
        waited = 0;
        while (!req_ack && waited < 8) begin
            @(negedge clk);
            #1;
            waited++;
        end
        chk(waited == wait_exp, "R7", "ack wait cycles", 32'(waited), 32'(wait_exp));
        // after acceptance: scramble every request and configuration input
        @(negedge clk);
        req_bank = 2'($urandom); req_row = 13'($urandom); req_col = 9'($urandom);
        cfg_rcd = 2'($urandom); cfg_cl = 2'($urandom); cfg_rp = 2'($urandom);
        req_valid = 1'b1;
        #1;
        pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(pins == cmd_of(2'd1), "R2", "activate pins", 32'(pins), 32'(cmd_of(2'd1)));
        chk(sd_ba == bank, "R2", "bank", 32'(sd_ba), 32'(bank));
        chk(sd_addr == row, "R2", "row", 32'(sd_addr), 32'(row));
        chk(!req_ack, "R8", "ack during activate", 32'(req_ack), 0);
        for (int i = 0; i < int'(rcd); i++) begin
            @(negedge clk);
            #1;
            pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            chk(pins == cmd_of(2'd0), "R3", "spacer nop", 32'(pins), 32'(cmd_of(2'd0)));
            chk(!req_ack, "R8", "ack during spacer", 32'(req_ack), 0);
        end
        for (int n = 0; n <= lat + 4; n++) begin
            @(negedge clk);
            if (n >= lat && n < lat + 4) sd_dq = beats[n - lat];
            else                         sd_dq = 16'($urandom);
            req_bank = 2'($urandom);
            #1;
            pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (n < 4) begin
                chk(pins == cmd_of(2'd2), "R4", "read pins", 32'(pins), 32'(cmd_of(2'd2)));
                chk(sd_addr == rd_addr(col, n), "R4", "column address",
                    32'(sd_addr), 32'(rd_addr(col, n)));
            end else if (n == lat + 4) begin
                chk(pins == cmd_of(2'd0), "R6", "transfer cycle nop",
                    32'(pins), 32'(cmd_of(2'd0)));
            end else begin
                chk(pins == cmd_of(2'd0), "R5", "latency nop", 32'(pins), 32'(cmd_of(2'd0)));
            end
            if (n - 1 >= lat && n - 1 < lat + 4) begin
                chk(rd_valid, "R5", "data valid", 32'(rd_valid), 1);
                chk(rd_data == beats[n - 1 - lat], "R5", "data beat",
                    32'(rd_data), 32'(beats[n - 1 - lat]));
            end else begin
                chk(!rd_valid, "R5", "no data valid", 32'(rd_valid), 0);
            end
            chk(!req_ack, "R8", "ack while busy", 32'(req_ack), 0);
        end
        req_valid = 1'b0;
        have_prev = 1'b1;
        prev_bank = bank;
        prev_rp = int'(rp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R6: actual=hung expected=idle");
        finish_run();
    end

    initial begin
        logic [3:0] pins;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(pins == cmd_of(2'd0), "R1", "reset nop", 32'(pins), 32'(cmd_of(2'd0)));
        chk(!rd_valid, "R1", "reset valid", 32'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(pins == cmd_of(2'd0), "R1", "post-reset nop", 32'(pins), 32'(cmd_of(2'd0)));
        chk(!req_ack, "R1", "no ack without request", 32'(req_ack), 0);

        // directed corners
        do_read(2'd1, 13'h0abc, 9'h010, 2'd0, 2'd0, 2'd0, 0); // shortest timings
        do_read(2'd1, 13'h1fff, 9'h1fe, 2'd3, 2'd3, 2'd3, 0); // longest, column wrap
        do_read(2'd1, 13'h0001, 9'h1ff, 2'd1, 2'd2, 2'd2, 0); // same bank, full block
        do_read(2'd1, 13'h0002, 9'h000, 2'd2, 2'd1, 2'd3, 1); // same bank, partial gap
        do_read(2'd2, 13'h0555, 9'h0aa, 2'd0, 2'd3, 2'd1, 0); // other bank, no block
        do_read(2'd2, 13'h0aaa, 9'h155, 2'd3, 2'd0, 2'd0, 3); // long gap

        for (int k = 0; k < 60; k++) begin
            do_read(2'($urandom), 13'($urandom), 9'($urandom), 2'($urandom),
                    2'($urandom), 2'($urandom), int'($urandom % 4));
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule